// File: doc/BRIEF.md
# Cascadable Four-Channel Countdown Timer Group

This block holds four programmable down-counters that share one prescaled time base and one group control word. Each counter has a base (reload) register, a readable current count, and two storage-only words (vector/priority and destination). A running counter counts down once per prescaler tick. When it expires it reloads its base value, flips a toggle flag and pulls its own active-low, level-sensitive interrupt line low. The line stays low until software writes that counter's destination word.

Neighbouring counters can be chained into one wider counter for long intervals. The lower counter of a pair supplies the low part over a full 32-bit range. The upper counter holds the high part, owns the pair's interrupt and its run/stop bit. Software reaches every register through a plain word-addressed write/read port, where reads are combinational.

Top module: `casc_timer_group`

## Requirements
- R1: Counter n register k sits at word address 16n+4k, with k=0 for current count, 1 for base, 2 for vector and 3 for destination. The group control word sits at word 64. Vector and destination words return the last value written. Group control reads back only bits 0-2, 8-9 and 24-26. Every other word reads zero.
- R2: After reset, every base word reads 0x8000_0000, every current count, vector and destination word reads 0, the group control word reads 0, and all interrupt lines are high.
- R3: While bit 31 of a counter's base word is set, its count holds still. Any base write loads the current count with the written value, and for a lone counter that value shows in bits 30:0 of the current count word.
- R4: Writes to a current count word are ignored.
- R5: Group control bits 9:8 set the tick period to 8, 16, 32 or 64 clock cycles (codes 0-3). A running lone counter steps once per tick.
- R6: A lone counter with base B expires on the tick that finds its count at zero. On expiry it reloads B, inverts bit 31 of its current count word and drives its interrupt low. Expirations therefore occur every B+1 ticks.
- R7: An interrupt line stays low until the destination word of that counter is written. Writes to the counter's other words do not release it.
- R8: Group control bit n (n=0,1,2) chains counter n (low half) with counter n+1 (high half). The low half's current count word then reads all 32 bits as count. The pair runs or holds according to bit 31 of the high half's base word.
- R9: When group control bit 24+n is set, a low half that ticks at zero while the high half is non-zero wraps to 0xFFFF_FFFF, and the high half steps down by one on the same tick.
- R10: When bit 24+n is clear, the low half reloads its own base on that tick instead. A pair with high base H and low base L then expires every (H+1)(L+1) ticks. Only the high half's interrupt goes low; the low half's interrupt stays high.
- R11: A chain bit n is ignored while counter n is already the high half of an active chain below it. The lowest chain wins, so with bits 0 and 1 both set, counter 2 runs alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 7 | Word address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| irq_n | output | 4 | Per-counter interrupt, active low, level |

## Verification
The bench goes after the expiry interval at every prescale code and at base zero. An off-by-one reload rule or a wrong divider would shift that interval by one tick or by a factor of two. It checks that only a destination write releases an interrupt; a design that clears on any write would release it early. In a chained pair it looks for the low half wrapping to all ones while the high half steps down, and for the (H+1)(L+1) period without rollover. A design that mixed up the two chain modes, or let the low half's bit 31 stop the pair, would show the wrong count or period. Finally it sets two overlapping chain bits and expects counter 2 to run alone; a design that honoured both bits would leave counter 2 waiting on a neighbour and never expiring.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
   typedef enum logic [1:0] {
      ROLE_LONE = 2'd0,
      ROLE_LOW  = 2'd1,
      ROLE_HIGH = 2'd2
   } role_e;

   // per-counter word kinds (address bits 3:2)
   localparam int KIND_CUR  = 0;
   localparam int KIND_BASE = 1;
   localparam int KIND_VEC  = 2;
   localparam int KIND_DST  = 3;

   // group control field positions
   localparam int CHAIN_LSB = 0;
   localparam int DIV_LSB   = 8;
   localparam int ROLL_LSB  = 24;
   localparam int GCTL_WORD = 64;
endpackage

// File: rtl/ctg_prescale.sv
module ctg_prescale #(
   parameter int DIV_LOG2 = 3,
   parameter int SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int PW = DIV_LOG2 + (1 << SEL_W) - 1;

   if (DIV_LOG2 < 1) begin : g_bad_div
      $error("ctg_prescale: DIV_LOG2 must be at least 1");
   end

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] lim;
   logic [PW:0]   span;

   always_comb begin
      span = (PW+1)'(1) << (DIV_LOG2 + int'(sel_i));
      lim  = PW'(span - (PW+1)'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else if (cnt_q >= lim) begin
         cnt_q  <= '0;
         tick_o <= 1'b1;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
         tick_o <= 1'b0;
      end
   end

   // ticks are single-cycle pulses separated by at least two cycles
   assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/ctg_chan.sv
module ctg_chan
   import ctg_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  role_e        role_i,
   input  logic         run_i,
   input  logic         roll_en_i,
   input  logic         partner_zero_i,
   input  logic         wr_base_i,
   input  logic         wr_ack_i,
   input  logic [W-1:0] wdata_i,
   output logic         zero_o,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] base_o,
   output logic         pend_o
);
   if (W < 8) begin : g_bad_w
      $error("ctg_chan: W must be at least 8");
   end

   logic [W-1:0] cnt_q, base_q, cnt_d;
   logic         tog_q, tog_d, pend_q, fire;
   logic         zero_full, zero_low;
   logic [W-2:0] low_m1;

   assign zero_full = (cnt_q == '0);
   assign zero_low  = (cnt_q[W-2:0] == '0);
   assign low_m1    = cnt_q[W-2:0] - 1'b1;
   assign zero_o    = (role_i == ROLE_LOW) ? zero_full : zero_low;

   always_comb begin
      cnt_d = cnt_q;
      tog_d = tog_q;
      fire  = 1'b0;
      if (tick_i && run_i) begin
         unique case (role_i)
            ROLE_LOW: begin
               if (zero_full)
                  cnt_d = (!partner_zero_i && roll_en_i) ? '1 : base_q;
               else
                  cnt_d = cnt_q - 1'b1;
            end
            ROLE_HIGH: begin
               if (partner_zero_i) begin
                  if (zero_low) begin
                     cnt_d = {1'b0, base_q[W-2:0]};
                     tog_d = ~tog_q;
                     fire  = 1'b1;
                  end else begin
                     cnt_d = {1'b0, low_m1};
                  end
               end
            end
            default: begin
               if (zero_low) begin
                  cnt_d = {1'b0, base_q[W-2:0]};
                  tog_d = ~tog_q;
                  fire  = 1'b1;
               end else begin
                  cnt_d = {1'b0, low_m1};
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= {1'b1, {(W-1){1'b0}}};
         cnt_q  <= '0;
         tog_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (wr_base_i) begin
            base_q <= wdata_i;
            cnt_q  <= wdata_i;
         end else begin
            cnt_q <= cnt_d;
            tog_q <= tog_d;
         end
         if (fire && !wr_base_i)
            pend_q <= 1'b1;
         else if (wr_ack_i)
            pend_q <= 1'b0;
      end
   end

   assign cur_o  = (role_i == ROLE_LOW) ? cnt_q : {tog_q, cnt_q[W-2:0]};
   assign base_o = base_q;
   assign pend_o = pend_q;

   assert_inhibit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !wr_base_i) |=> $stable(cnt_q));
   assert_irq_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> $past(tick_i));
   assert_toggle_with_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tog_q) |-> pend_q);
   assert_high_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (role_i == ROLE_HIGH && !partner_zero_i && !wr_base_i) |=> $stable(cnt_q));
   assert_low_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q) |-> ($past(role_i) != ROLE_LOW));
endmodule

// File: rtl/casc_timer_group.sv
module casc_timer_group
   import ctg_pkg::*;
#(
   parameter int N_TMR    = 4,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 7,
   parameter int DIV_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [N_TMR-1:0]  irq_n
);
   localparam int NC = N_TMR - 1;

   if (N_TMR < 2 || N_TMR > 4) begin : g_bad_n
      $error("casc_timer_group: N_TMR must be 2..4");
   end
   if (DATA_W < ROLL_LSB + NC) begin : g_bad_w
      $error("casc_timer_group: DATA_W too small for rollover field");
   end
   if (ADDR_W < 7) begin : g_bad_a
      $error("casc_timer_group: ADDR_W must be at least 7");
   end

   // address decode
   logic [1:0] idx, kind;
   logic       is_tmr, is_gctl;
   assign idx     = addr[5:4];
   assign kind    = addr[3:2];
   assign is_tmr  = (addr[ADDR_W-1:6] == '0) && (addr[1:0] == 2'b00) &&
                    (int'(idx) < N_TMR);
   assign is_gctl = (addr == ADDR_W'(GCTL_WORD));

   // group control
   logic [NC-1:0] chain_q, roll_q, eff;
   logic [1:0]    div_q;
   logic          tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         roll_q  <= '0;
         div_q   <= 2'd0;
      end else if (wr_en && is_gctl) begin
         chain_q <= wdata[CHAIN_LSB +: NC];
         roll_q  <= wdata[ROLL_LSB +: NC];
         div_q   <= wdata[DIV_LSB +: 2];
      end
   end

   // lowest chain wins where two requested chains share a counter
   always_comb begin
      logic prev, t;
      prev = 1'b0;
      for (int i = 0; i < NC; i++) begin
         t      = chain_q[i] & ~prev;
         eff[i] = t;
         prev   = t;
      end
   end

   ctg_prescale #(.DIV_LOG2(DIV_LOG2), .SEL_W(2)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (div_q),
      .tick_o (tick)
   );

   logic [DATA_W-1:0] cur_rd  [N_TMR];
   logic [DATA_W-1:0] base_rd [N_TMR];
   logic [DATA_W-1:0] vec_rd  [N_TMR];
   logic [DATA_W-1:0] dst_rd  [N_TMR];
   logic [N_TMR-1:0]  zero, pend;

   for (genvar n = 0; n < N_TMR; n++) begin : g_ch
      logic  lo_ok, hi_ok, up_zero, up_run, up_roll, dn_zero;
      logic  wr_base, wr_vec, wr_dst, run;
      role_e role;
      logic [DATA_W-1:0] vec_r, dst_r;

      if (n < N_TMR - 1) begin : g_up
         assign lo_ok   = eff[n];
         assign up_zero = zero[n+1];
         assign up_run  = ~base_rd[n+1][DATA_W-1];
         assign up_roll = roll_q[n];
      end else begin : g_noup
         assign lo_ok   = 1'b0;
         assign up_zero = 1'b0;
         assign up_run  = 1'b0;
         assign up_roll = 1'b0;
      end
      if (n > 0) begin : g_dn
         assign hi_ok   = eff[n-1];
         assign dn_zero = zero[n-1];
      end else begin : g_nodn
         assign hi_ok   = 1'b0;
         assign dn_zero = 1'b0;
      end

      assign role = lo_ok ? ROLE_LOW : (hi_ok ? ROLE_HIGH : ROLE_LONE);
      assign run  = lo_ok ? up_run : ~base_rd[n][DATA_W-1];

      assign wr_base = wr_en && is_tmr && (idx == 2'(n)) && (kind == 2'(KIND_BASE));
      assign wr_vec  = wr_en && is_tmr && (idx == 2'(n)) && (kind == 2'(KIND_VEC));
      assign wr_dst  = wr_en && is_tmr && (idx == 2'(n)) && (kind == 2'(KIND_DST));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vec_r <= '0;
            dst_r <= '0;
         end else begin
            if (wr_vec) vec_r <= wdata;
            if (wr_dst) dst_r <= wdata;
         end
      end
      assign vec_rd[n] = vec_r;
      assign dst_rd[n] = dst_r;

      ctg_chan #(.W(DATA_W)) u_ch (
         .clk            (clk),
         .rst_n          (rst_n),
         .tick_i         (tick),
         .role_i         (role),
         .run_i          (run),
         .roll_en_i      (up_roll),
         .partner_zero_i (lo_ok ? up_zero : dn_zero),
         .wr_base_i      (wr_base),
         .wr_ack_i       (wr_dst),
         .wdata_i        (wdata),
         .zero_o         (zero[n]),
         .cur_o          (cur_rd[n]),
         .base_o         (base_rd[n]),
         .pend_o         (pend[n])
      );
   end

   always_comb begin
      rdata = '0;
      if (is_gctl) begin
         rdata[CHAIN_LSB +: NC] = chain_q;
         rdata[DIV_LSB +: 2]    = div_q;
         rdata[ROLL_LSB +: NC]  = roll_q;
      end else if (is_tmr) begin
         unique case (kind)
            2'(KIND_CUR):  rdata = cur_rd[idx];
            2'(KIND_BASE): rdata = base_rd[idx];
            2'(KIND_VEC):  rdata = vec_rd[idx];
            default:       rdata = dst_rd[idx];
         endcase
      end
   end

   assign irq_n = ~pend;

   // chained pairs never overlap
   assert_chain_disjoint_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(eff) <= (NC + 1) / 2);
endmodule

// File: tb/casc_timer_group_bench.sv
module casc_timer_group_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [6:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [3:0]  irq_n;

   int    checks = 0;
   int    errors = 0;
   longint cyc = 0;
   bit    done = 1'b0;

   // table: {prescale code, base value}
   localparam int TBL_N = 5;
   localparam int TBL [TBL_N][2] = '{'{0, 3}, '{1, 2}, '{2, 1}, '{3, 0}, '{0, 0}};

   casc_timer_group u_casc_timer_group (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .irq_n (irq_n)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [6:0] w(input int n, input int k);
      return 7'(16 * n + 4 * k);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      addr  = a;
      wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [6:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_low(input int n, output longint t);
      t = -1;
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         if (irq_n[n] == 1'b0) begin
            t = cyc;
            break;
         end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, v2;
      longint t1, t2;
      bit found;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R2 reset state
      #1;
      chk("R2 irq_n", {28'd0, irq_n}, 32'h0000_000F);
      for (int n = 0; n < 4; n++) begin
         rd(w(n, 1), v); chk("R2 base", v, 32'h8000_0000);
         rd(w(n, 0), v); chk("R2 cur", v, 32'h0);
         rd(w(n, 2), v); chk("R2 vec", v, 32'h0);
         rd(w(n, 3), v); chk("R2 dst", v, 32'h0);
      end
      rd(7'd64, v); chk("R2 gctl", v, 32'h0);

      // R1 register map
      wr(w(2, 2), 32'hA5A5_1234);
      wr(w(1, 3), 32'h0000_0F0F);
      rd(w(2, 2), v); chk("R1 vec2", v, 32'hA5A5_1234);
      rd(w(3, 2), v); chk("R1 vec3 untouched", v, 32'h0);
      rd(w(1, 3), v); chk("R1 dst1", v, 32'h0000_0F0F);
      rd(7'd1, v);    chk("R1 unmapped 1", v, 32'h0);
      rd(7'd65, v);   chk("R1 unmapped 65", v, 32'h0);
      rd(7'd127, v);  chk("R1 unmapped 127", v, 32'h0);
      wr(7'd64, 32'hFFFF_FFFF);
      rd(7'd64, v);   chk("R1 gctl fields", v, 32'h0700_0307);
      wr(7'd64, 32'h0);

      // R4 current count not writable
      wr(w(0, 0), 32'h0000_1234);
      rd(w(0, 0), v); chk("R4 cur write ignored", v, 32'h0);

      // R3 base write loads count, inhibit holds it
      wr(w(0, 1), 32'h8000_0010);
      rd(w(0, 0), v); chk("R3 load on base write", v, 32'h0000_0010);
      repeat (200) @(negedge clk);
      rd(w(0, 0), v); chk("R3 inhibited hold", v, 32'h0000_0010);

      // R5 R6 expiry interval across prescale codes (timer 3)
      for (int i = 0; i < TBL_N; i++) begin
         wr(7'd64, 32'(TBL[i][0]) << 8);
         wr(w(3, 1), 32'h8000_0000 | 32'(TBL[i][1]));
         wr(w(3, 3), 32'h0);
         wr(w(3, 1), 32'(TBL[i][1]));
         wait_low(3, t1);
         wr(w(3, 3), 32'h0);
         wait_low(3, t2);
         chk("R5 R6 expiry interval", 32'(t2 - t1),
             32'((TBL[i][1] + 1) * (8 << TBL[i][0])));
      end
      wr(w(3, 1), 32'h8000_0000);
      wr(w(3, 3), 32'h0);
      wr(7'd64, 32'h0);

      // R6 toggle flag, R7 acknowledge (timer 2)
      wr(w(2, 1), 32'h0000_0002);
      wait_low(2, t1);
      rd(w(2, 0), v); chk("R6 toggle set and reload", v, 32'h8000_0002);
      wr(w(2, 3), 32'h0);
      wait_low(2, t1);
      rd(w(2, 0), v); chk("R6 toggle cleared", v, 32'h0000_0002);
      wr(w(2, 1), 32'h8000_0002);
      repeat (40) @(negedge clk);
      chk("R7 irq held", {31'd0, irq_n[2]}, 32'h0);
      wr(w(2, 2), 32'h1);
      wr(w(2, 0), 32'h0);
      chk("R7 other writes keep irq", {31'd0, irq_n[2]}, 32'h0);
      wr(w(2, 3), 32'h0);
      chk("R7 dest write releases", {31'd0, irq_n[2]}, 32'h1);

      // R8 R9 chained pair 0/1 with rollover
      wr(7'd64, 32'h0100_0001);
      wr(w(1, 1), 32'h8000_0003);
      wr(w(0, 1), 32'h0000_0002);
      repeat (50) @(negedge clk);
      rd(w(0, 0), v); chk("R8 pair held by high bit31", v, 32'h0000_0002);
      wr(w(1, 1), 32'h0000_0003);
      found = 1'b0;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         addr = w(0, 0);
         #1;
         if (rdata == 32'hFFFF_FFFF) begin
            found = 1'b1;
            break;
         end
      end
      chk("R8 R9 low half wraps to full 32 bits", {31'd0, found}, 32'h1);
      rd(w(1, 0), v); chk("R9 high stepped on wrap", v, 32'h0000_0002);
      chk("R9 no irq yet", {28'd0, irq_n}, 32'h0000_000F);
      wr(w(1, 1), 32'h8000_0003);
      rd(w(0, 0), v);
      repeat (40) @(negedge clk);
      rd(w(0, 0), v2); chk("R8 low held after high stop", v2, v);

      // R10 chained pair without rollover
      wr(7'd64, 32'h0000_0001);
      wr(w(1, 1), 32'h8000_0001);
      wr(w(0, 1), 32'h0000_0002);
      wr(w(1, 1), 32'h0000_0001);
      wait_low(1, t1);
      wr(w(1, 3), 32'h0);
      wait_low(1, t2);
      chk("R10 pair period", 32'(t2 - t1), 32'(2 * 3 * 8));
      chk("R10 low half irq quiet", {31'd0, irq_n[0]}, 32'h1);
      wr(w(1, 1), 32'h8000_0001);
      wr(w(1, 3), 32'h0);

      // R11 overlapping chain bits: counter 2 runs alone
      wr(7'd64, 32'h0000_0003);
      wr(w(2, 3), 32'h0);
      wr(w(2, 1), 32'h0000_0001);
      wait_low(2, t1);
      wr(w(2, 3), 32'h0);
      wait_low(2, t2);
      chk("R11 counter 2 lone period", 32'(t2 - t1), 32'(2 * 8));
      wr(w(2, 1), 32'h8000_0001);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule